// File: doc/BRIEF.md
# Random number generator control front end

This block is the register and interrupt front end of a random number generator. Software reaches it over a single-cycle 32-bit register port. Through it, software reads an identification word and issues seed and self-test commands. It sets interrupt masks and the automatic reseed enable, polls status, reads an error code and pops random words from an output FIFO. A sequencer runs one operation at a time with a fixed latency. It latches a done event when the operation finishes and drives one level interrupt from the done and error conditions.

The entropy source and the hash core are not modelled. A 32-bit xorshift generator refills the FIFO one word per cycle while the generator is seeded, idle and free of errors. A test input makes the next seed operation end in a statistical failure, so that the software retry path can be exercised. With automatic reseeding enabled, a counter of popped words starts a new seed operation once a parameter-sized limit is reached.

Top module: `rng_ctrl_top`

## Requirements
- R1: A read at byte address 0x00 returns the identification word {type[3:0], 12'h000, major[7:0], minor[7:0]}. With the default parameters it is 0x20000123 (type code 2).
- R2: The command register at 0x04 acts only at the cycle of the write and always reads 0. Its bits are: bit 0 starts a self-test, bit 1 starts a seed, bit 4 clears the interrupt, bit 5 clears the error.
- R3: The control register at 0x08 stores bit 4 (automatic reseed enable), bit 5 (done interrupt mask) and bit 6 (error interrupt mask). All its other bits read 0, and it resets to 0.
- R4: A seed command finishes OP_LAT cycles later and sets status bit 5. After a successful seed the FIFO fills to DEPTH words, and status bits 11:8 show the fill level.
- R5: A self-test command finishes OP_LAT cycles later and sets status bit 4.
- R6: A seed or self-test command written while an operation is running has no effect.
- R7: A read at 0x14 returns the FIFO head word and pops it. Consecutive words differ and are nonzero. A read of an empty FIFO returns 0 and leaves the level unchanged.
- R8: irq_o = ((status bit 4 OR status bit 5) AND NOT control bit 5) OR (error pending AND NOT control bit 6). It is 0 after reset.
- R9: The clear-interrupt command clears status bits 4 and 5 only when the error register is 0. Otherwise it has no effect.
- R10: The clear-error command zeroes the error register and clears status bits 4, 5 and 16.
- R11: A seed that ends with force_stat_err_i high sets the error register at 0x10 to 0x00000008 and status bit 16. Word generation then stops until a later seed succeeds.
- R12: With control bit 4 set, a seed operation starts by itself once RESEED_WORDS words have been popped since the last seed. Fewer pops start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Level interrupt |
| force_stat_err_i | input | 1 | Test input: the seed that ends while it is high fails the statistical test |

## Verification
Assertions check the following on every cycle: a running operation keeps its kind until it ends, the FIFO count never exceeds its depth, a pop without a push lowers the count by one, the error register holds only 0 or the statistical code, clear-error empties it, and clear-interrupt keeps a done flag while an error is pending. Other behaviour can only be shown by the bench's scenarios. These are the register values, the interrupt under each mask, the retry after a forced failure, the refusal of a command during a running seed, the behaviour of an empty FIFO, and the reseed that starts only on the exact word count.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_VER  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CMD  = 8'h04;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h0C;
  localparam logic [ADDR_W-1:0] A_ERR  = 8'h10;
  localparam logic [ADDR_W-1:0] A_FIFO = 8'h14;

  localparam int CMD_TEST    = 0;
  localparam int CMD_SEED    = 1;
  localparam int CMD_CLR_INT = 4;
  localparam int CMD_CLR_ERR = 5;

  localparam int CTL_AUTO  = 4;
  localparam int CTL_MDONE = 5;
  localparam int CTL_MERR  = 6;

  localparam int ST_TEST = 4;
  localparam int ST_SEED = 5;
  localparam int ST_LVL  = 8;
  localparam int ST_ERR  = 16;
  localparam int LVL_W   = 4;

  localparam logic [31:0] ERR_STAT = 32'h0000_0008;

  typedef enum logic [1:0] {OP_IDLE, OP_SEED, OP_TEST} op_e;
endpackage

// File: rtl/rng_ctrl_seq.sv
module rng_ctrl_seq
  import rng_ctrl_pkg::*;
#(
  parameter int OP_LAT       = 16,
  parameter int RESEED_WORDS = 1 << 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_test_i,
  input  logic        start_seed_i,
  input  logic        clr_int_i,
  input  logic        clr_err_i,
  input  logic        pop_i,
  input  logic        auto_en_i,
  input  logic        force_err_i,
  output logic        st_done_o,
  output logic        seed_done_o,
  output logic [31:0] err_o,
  output logic        gen_en_o
);
  localparam int LAT_W = $clog2(OP_LAT + 1);
  localparam int SRV_W = $clog2(RESEED_WORDS + 1);

  op_e              op_q;
  logic [LAT_W-1:0] cnt_q;
  logic [SRV_W-1:0] served_q;
  logic             seeded_q, st_done_q, seed_done_q;
  logic [31:0]      err_q;
  logic             auto_trig, go_test, go_seed, op_end, seed_end, test_end;

  assign auto_trig = auto_en_i && (served_q == SRV_W'(RESEED_WORDS));
  assign go_test   = (op_q == OP_IDLE) && start_test_i;
  assign go_seed   = (op_q == OP_IDLE) && !start_test_i && (start_seed_i || auto_trig);
  assign op_end    = (op_q != OP_IDLE) && (cnt_q == '0);
  assign seed_end  = op_end && (op_q == OP_SEED);
  assign test_end  = op_end && (op_q == OP_TEST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (go_test || go_seed) begin
      op_q  <= go_test ? OP_TEST : OP_SEED;
      cnt_q <= LAT_W'(OP_LAT - 1);
    end else if (op_end) begin
      op_q <= OP_IDLE;
    end else if (op_q != OP_IDLE) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // pop counter for automatic reseed, restarts on every seed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) served_q <= '0;
    else if (go_seed) served_q <= '0;
    else if (pop_i && served_q != SRV_W'(RESEED_WORDS)) served_q <= served_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q    <= 1'b0;
      err_q       <= '0;
      st_done_q   <= 1'b0;
      seed_done_q <= 1'b0;
    end else begin
      if (seed_end) seeded_q <= !force_err_i;
      if (seed_end && force_err_i) err_q <= ERR_STAT;
      else if (clr_err_i) err_q <= '0;
      // done flags: set wins; clear-int is blocked by a pending error
      if (test_end) st_done_q <= 1'b1;
      else if (clr_err_i || (clr_int_i && err_q == '0)) st_done_q <= 1'b0;
      if (seed_end) seed_done_q <= 1'b1;
      else if (clr_err_i || (clr_int_i && err_q == '0)) seed_done_q <= 1'b0;
    end
  end

  assign st_done_o   = st_done_q;
  assign seed_done_o = seed_done_q;
  assign err_o       = err_q;
  assign gen_en_o    = seeded_q && (op_q != OP_SEED) && (err_q == '0);

  p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_IDLE && cnt_q != '0) |=> op_q == $past(op_q));
  p_err_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q == '0) || (err_q == ERR_STAT));
  p_clr_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !seed_end) |=> err_q == '0);
  p_clr_int_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_int_i && !clr_err_i && err_q != '0 && seed_done_q) |=> seed_done_q);
endmodule

// File: rtl/rng_ctrl_fifo.sv
module rng_ctrl_fifo #(
  parameter int          DEPTH = 8,
  parameter logic [31:0] SEED  = 32'h2545_F491,
  localparam int         PTR_W = $clog2(DEPTH),
  localparam int         CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_en_i,
  input  logic             pop_i,
  output logic [31:0]      word_o,
  output logic [CNT_W-1:0] level_o
);
  logic [31:0]      mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] count_q;
  logic [31:0]      lfsr_q, lfsr_d;
  logic             push;

  always_comb begin
    lfsr_d = lfsr_q ^ (lfsr_q << 13);
    lfsr_d = lfsr_d ^ (lfsr_d >> 17);
    lfsr_d = lfsr_d ^ (lfsr_d << 5);
  end

  assign push = gen_en_i && (count_q != CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      lfsr_q  <= SEED;
    end else begin
      if (push) begin
        wr_q   <= wr_q + 1'b1;
        lfsr_q <= lfsr_d;
      end
      if (pop_i) rd_q <= rd_q + 1'b1;
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_q] <= lfsr_d;
  end

  assign word_o  = mem_q[rd_q];
  assign level_o = count_q;

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_pop_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push) |=> count_q == $past(count_q) - CNT_W'(1));
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_ctrl_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'd2,
  parameter logic [7:0] REV_MAJ   = 8'h01,
  parameter logic [7:0] REV_MIN   = 8'h23,
  parameter int         CNT_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              start_test_o,
  output logic              start_seed_o,
  output logic              clr_int_o,
  output logic              clr_err_o,
  output logic              pop_o,
  output logic              auto_en_o,
  input  logic              st_done_i,
  input  logic              seed_done_i,
  input  logic [31:0]       err_i,
  input  logic [CNT_W-1:0]  level_i,
  input  logic [31:0]       word_i
);
  logic        cmd_wr, ctrl_wr, empty;
  logic        auto_q, mdone_q, merr_q;
  logic [31:0] stat;
  logic        unused_wdata;

  assign cmd_wr  = req_i && we_i && (addr_i == A_CMD);
  assign ctrl_wr = req_i && we_i && (addr_i == A_CTRL);
  assign empty   = (level_i == '0);

  assign start_test_o = cmd_wr && wdata_i[CMD_TEST];
  assign start_seed_o = cmd_wr && wdata_i[CMD_SEED];
  assign clr_int_o    = cmd_wr && wdata_i[CMD_CLR_INT];
  assign clr_err_o    = cmd_wr && wdata_i[CMD_CLR_ERR];
  assign pop_o        = req_i && !we_i && (addr_i == A_FIFO) && !empty;
  assign unused_wdata = ^{wdata_i[31:7], wdata_i[3:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q  <= 1'b0;
      mdone_q <= 1'b0;
      merr_q  <= 1'b0;
    end else if (ctrl_wr) begin
      auto_q  <= wdata_i[CTL_AUTO];
      mdone_q <= wdata_i[CTL_MDONE];
      merr_q  <= wdata_i[CTL_MERR];
    end
  end

  always_comb begin
    stat = '0;
    stat[ST_TEST] = st_done_i;
    stat[ST_SEED] = seed_done_i;
    stat[ST_LVL +: LVL_W] = LVL_W'(level_i);
    stat[ST_ERR] = (err_i != '0);
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        A_VER:   rdata_o = {TYPE_CODE, 12'h000, REV_MAJ, REV_MIN};
        A_CTRL:  rdata_o = {25'd0, merr_q, mdone_q, auto_q, 4'd0};
        A_STAT:  rdata_o = stat;
        A_ERR:   rdata_o = err_i;
        A_FIFO:  rdata_o = empty ? 32'd0 : word_i;
        default: rdata_o = '0;
      endcase
    end
  end

  assign auto_en_o = auto_q;
  assign irq_o = ((st_done_i || seed_done_i) && !mdone_q) || ((err_i != '0) && !merr_q);
endmodule

// File: rtl/rng_ctrl_top.sv
module rng_ctrl_top
  import rng_ctrl_pkg::*;
#(
  parameter int OP_LAT       = 16,
  parameter int DEPTH        = 8,
  parameter int RESEED_WORDS = 1 << 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  input  logic              force_stat_err_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              start_test, start_seed, clr_int, clr_err, pop, auto_en;
  logic              st_done, seed_done, gen_en;
  logic [31:0]       err, word;
  logic [CNT_W-1:0]  level;

  rng_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o,
    .start_test_o(start_test), .start_seed_o(start_seed),
    .clr_int_o(clr_int), .clr_err_o(clr_err), .pop_o(pop), .auto_en_o(auto_en),
    .st_done_i(st_done), .seed_done_i(seed_done), .err_i(err),
    .level_i(level), .word_i(word)
  );

  rng_ctrl_seq #(.OP_LAT(OP_LAT), .RESEED_WORDS(RESEED_WORDS)) u_seq (
    .clk_i, .rst_ni,
    .start_test_i(start_test), .start_seed_i(start_seed),
    .clr_int_i(clr_int), .clr_err_i(clr_err), .pop_i(pop),
    .auto_en_i(auto_en), .force_err_i(force_stat_err_i),
    .st_done_o(st_done), .seed_done_o(seed_done), .err_o(err), .gen_en_o(gen_en)
  );

  rng_ctrl_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .gen_en_i(gen_en), .pop_i(pop), .word_o(word), .level_o(level)
  );
endmodule

// File: tb/rng_ctrl_top_test.sv
module rng_ctrl_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, force_err = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rng_ctrl_top #(.OP_LAT(8), .DEPTH(8), .RESEED_WORDS(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .force_stat_err_i(force_err)
  );

  // {address, expected} after reset
  localparam logic [39:0] RST_VEC [7] = '{
    {8'h00, 32'h2000_0123},  // R1
    {8'h04, 32'h0},          // R2
    {8'h08, 32'h0},          // R3
    {8'h0C, 32'h0},          // R4
    {8'h10, 32'h0},          // R11
    {8'h14, 32'h0},          // R7 empty
    {8'h18, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, w1, w2;
    idle(2); rst_n = 1'b1; idle(1);
    for (int i = 0; i < 7; i++) begin
      rd(RST_VEC[i][39:32], v);
      check($sformatf("reset vector %0d", i), v, RST_VEC[i][31:0]);
    end
    check("R8 irq after reset", {31'd0, irq}, 32'd0);

    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check("R3 ctrl bits", v, 32'h70);
    wr(8'h08, 32'h0);

    wr(8'h04, 32'h2); wr(8'h04, 32'h1);          // second command lands while busy
    idle(20); rd(8'h0C, v);
    check("R4 R6 seed done, full, no self-test", v, 32'h820);
    check("R8 irq on done", {31'd0, irq}, 32'd1);
    rd(8'h04, v); check("R2 cmd reads zero", v, 32'h0);
    wr(8'h08, 32'h20); idle(1); check("R8 done masked", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h10); rd(8'h0C, v); check("R9 clear int no error", v, 32'h800);
    check("R8 irq cleared", {31'd0, irq}, 32'd0);

    rd(8'h14, w1); rd(8'h14, w2);
    check("R7 word nonzero", {31'd0, w1 != 0 && w2 != 0}, 32'd1);
    check("R7 words differ", {31'd0, w1 != w2}, 32'd1);

    force_err = 1'b1; wr(8'h04, 32'h2); idle(12); force_err = 1'b0;
    rd(8'h0C, v); check("R11 error status", v, 32'h10820);
    rd(8'h10, v); check("R11 error code", v, 32'h8);
    for (int i = 0; i < 8; i++) rd(8'h14, w1);
    idle(4); rd(8'h0C, v); check("R11 no refill after error", v, 32'h10020);
    rd(8'h14, v); check("R7 empty read zero", v, 32'h0);
    rd(8'h0C, v); check("R7 empty read keeps level", v, 32'h10020);
    wr(8'h08, 32'h20); idle(1); check("R8 error unmasked", {31'd0, irq}, 32'd1);
    wr(8'h08, 32'h60); idle(1); check("R8 both masked", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h10); rd(8'h0C, v); check("R9 clear int blocked", v, 32'h10020);
    wr(8'h04, 32'h20); rd(8'h0C, v); check("R10 clear err status", v, 32'h0);
    rd(8'h10, v); check("R10 error reg", v, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'd0);

    wr(8'h04, 32'h2); idle(20); rd(8'h0C, v); check("R11 retry seed", v, 32'h820);

    wr(8'h04, 32'h10); wr(8'h04, 32'h1); idle(12);
    rd(8'h0C, v); check("R5 self-test done", v, 32'h810);

    wr(8'h04, 32'h10); wr(8'h08, 32'h10);
    for (int i = 0; i < 3; i++) rd(8'h14, w1);
    idle(20); rd(8'h0C, v); check("R12 no reseed below limit", v, 32'h800);
    rd(8'h14, w1);
    idle(20); rd(8'h0C, v); check("R12 auto reseed", v, 32'h820);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule